// File: doc/BRIEF.md
# EPROM Byte Program-and-Verify Sequencer

This block writes a single byte into a UV-erasable EPROM and then reads it back to confirm the write. A host presents a 19-bit address and an 8-bit data byte with a one-cycle command strobe. The sequencer then runs the whole sequence by itself. It raises the core-supply boost enable, then the programming-supply enable, and drives address, data and a high output enable for the setup time. It pulls the chip-enable/program strobe low for the pulse width and holds the data after the pulse. It then releases its data drivers, reads the cell back with output enable low, waits for the bus to float, and lowers the supply enables in reverse order. It ends with a one-cycle done strobe carrying a pass flag.

Every interval is given in nanoseconds as a parameter and converted to whole clock cycles (rounded up) from a clock-period parameter. The analog supplies, the voltage levels and any retry policy sit outside this block. The block only issues the digital enables and strobes in the right order and for the right number of cycles.

Top module: `eprom_pgm_seq`

## Requirements
- R1: After reset, mem_ce_pgm_n and mem_oe_n are 1, vcc_hi_en, vpp_en, mem_dq_oe, busy and done are 0.
- R2: vcc_hi_en rises exactly 1 cycle before vpp_en rises and falls exactly 1 cycle after vpp_en falls. vpp_en is never 1 while vcc_hi_en is 0.
- R3: mem_ce_pgm_n is 0 only while both vpp_en and vcc_hi_en are 1, so the strobe is high whenever the programming supply switches on.
- R4: mem_dq_oe rises together with vpp_en, and mem_ce_pgm_n falls exactly ceil(SETUP_NS/CLK_PERIOD_NS) cycles later (200 at defaults). At that point the address and data equal the command and mem_oe_n is 1.
- R5: mem_ce_pgm_n stays 0 for exactly ceil(PULSE_NS/CLK_PERIOD_NS) cycles (10000 at defaults). A PULSE_NS outside 45000..105000 stops elaboration.
- R6: mem_dq_out keeps the command data and mem_dq_oe stays 1 for exactly ceil(HOLD_NS/CLK_PERIOD_NS) cycles (200) after mem_ce_pgm_n rises. mem_addr holds the command address for the whole operation.
- R7: mem_dq_oe falls exactly 1 cycle before mem_oe_n falls, and the two are never both asserted.
- R8: mem_oe_n stays 0 for exactly ceil(READ_NS/CLK_PERIOD_NS) cycles (20). mem_dq_in is sampled on the last of those cycles.
- R9: vpp_en falls exactly ceil(FLOAT_NS/CLK_PERIOD_NS) cycles (12) after mem_oe_n rises.
- R10: done is a one-cycle pulse in the cycle vcc_hi_en falls. pass is 1 when the sampled byte equals the command data and 0 otherwise. busy is 1 from the cycle after acceptance through the done cycle and 0 after it.
- R11: cmd_valid is ignored while busy is 1: address, data and timing of the running operation are unchanged and only one done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe, taken when idle |
| cmd_addr | input | 19 | Byte address to program |
| cmd_data | input | 8 | Byte value to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation strobe |
| pass | output | 1 | Read-back matched the written byte (valid with done) |
| mem_addr | output | 19 | Address bus to the EPROM |
| mem_dq_out | output | 8 | Data driven onto the EPROM data bus |
| mem_dq_oe | output | 1 | Enable for the data bus drivers |
| mem_dq_in | input | 8 | Data read from the EPROM data bus |
| mem_oe_n | output | 1 | EPROM output enable, active low |
| mem_ce_pgm_n | output | 1 | EPROM chip-enable/program strobe, active low |
| vcc_hi_en | output | 1 | Enable for the raised core supply |
| vpp_en | output | 1 | Enable for the programming supply |

## Verification
Operations are run with all-zero, all-one and alternating address and data patterns. Each one measures every interval from supply enable to supply disable, so a wrong count in any single phase shows up as a mismatch in that phase alone. The read-back path is tried with a correct byte and with a byte flipped in bit 0 or in bit 7. This separates a true compare from one that ignores a bit or has a stuck result. A second command pushed in the middle of a run, with inverted address and data, shows whether the running operation can be disturbed or restarted.

// File: rtl/eprom_pgm_pkg.sv
// Shared types and helpers for the EPROM program-and-verify sequencer.
// Assumes all timing parameters are given in whole nanoseconds.
package eprom_pgm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_VCC_ON,
        ST_SETUP,
        ST_PULSE,
        ST_HOLD,
        ST_RELEASE,
        ST_READ,
        ST_FLOAT,
        ST_VPP_OFF,
        ST_DONE
    } seq_state_t;

    // Round a nanosecond interval up to whole clock cycles.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period);
        return (ns + period - 1) / period;
    endfunction

endpackage

// File: rtl/eprom_pgm_timer.sv
// Down-counting interval timer. Loaded with N-1, it reports expiry on the
// N-th cycle after the load. Assumes the caller loads on a state change.
module eprom_pgm_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load a new interval or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/eprom_pgm_verify.sv
// Read-back comparator. It captures the compare result when told to and
// holds it until the next capture. Assumes rd_data is settled on capture.
module eprom_pgm_verify #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] exp_data,
    output logic              match_q
);

    // Register the byte compare at the end of the read window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            match_q <= 1'b0;
        else if (capture)
            match_q <= (rd_data == exp_data);
    end

endmodule

// File: rtl/eprom_pgm_fsm.sv
// Phase sequencer. It steps through supply-up, setup, pulse, hold, bus
// release, read, float and supply-down, and loads the interval timer at
// each timed phase. It latches the command only when idle.
module eprom_pgm_fsm
    import eprom_pgm_pkg::*;
#(
    parameter int unsigned ADDR_W  = 19,
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned CNT_W   = 14,
    parameter int unsigned SETUP_C = 200,
    parameter int unsigned PULSE_C = 10000,
    parameter int unsigned HOLD_C  = 200,
    parameter int unsigned READ_C  = 20,
    parameter int unsigned FLOAT_C = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              tmr_expired,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output seq_state_t        state_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    seq_state_t state_d;

    // Pick the next phase and the interval for the timer.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE:    if (cmd_valid) state_d = ST_VCC_ON;
            ST_VCC_ON: begin
                state_d  = ST_SETUP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(SETUP_C - 1);
            end
            ST_SETUP: if (tmr_expired) begin
                state_d  = ST_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(PULSE_C - 1);
            end
            ST_PULSE: if (tmr_expired) begin
                state_d  = ST_HOLD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(HOLD_C - 1);
            end
            ST_HOLD:    if (tmr_expired) state_d = ST_RELEASE;
            ST_RELEASE: begin
                state_d  = ST_READ;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(READ_C - 1);
            end
            ST_READ: if (tmr_expired) begin
                state_d  = ST_FLOAT;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(FLOAT_C - 1);
            end
            ST_FLOAT:   if (tmr_expired) state_d = ST_VPP_OFF;
            ST_VPP_OFF: state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Advance the phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Capture the command only while idle, so later strobes are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == ST_IDLE && cmd_valid) begin
            addr_q <= cmd_addr;
            data_q <= cmd_data;
        end
    end

endmodule

// File: rtl/eprom_pgm_seq.sv
// Top of the EPROM byte program-and-verify sequencer. It converts the
// nanosecond parameters to cycles, wires the phase FSM, timer and
// comparator, and decodes the pin levels from the phase. Assumes the
// external supplies follow their enables and the bus is driven by
// mem_dq_out only while mem_dq_oe is high.
module eprom_pgm_seq
    import eprom_pgm_pkg::*;
#(
    parameter int unsigned ADDR_W        = 19,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 5,
    parameter int unsigned SETUP_NS      = 1000,
    parameter int unsigned PULSE_NS      = 50000,
    parameter int unsigned HOLD_NS       = 1000,
    parameter int unsigned READ_NS       = 100,
    parameter int unsigned FLOAT_NS      = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_oe_n,
    output logic              mem_ce_pgm_n,
    output logic              vcc_hi_en,
    output logic              vpp_en
);

    localparam int unsigned SETUP_C = ns_to_cycles(SETUP_NS, CLK_PERIOD_NS);
    localparam int unsigned PULSE_C = ns_to_cycles(PULSE_NS, CLK_PERIOD_NS);
    localparam int unsigned HOLD_C  = ns_to_cycles(HOLD_NS,  CLK_PERIOD_NS);
    localparam int unsigned READ_C  = ns_to_cycles(READ_NS,  CLK_PERIOD_NS);
    localparam int unsigned FLOAT_C = ns_to_cycles(FLOAT_NS, CLK_PERIOD_NS);
    localparam int unsigned MAX_AB  = (SETUP_C > PULSE_C) ? SETUP_C : PULSE_C;
    localparam int unsigned MAX_CD  = (HOLD_C > READ_C) ? HOLD_C : READ_C;
    localparam int unsigned MAX_ABCD = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned MAX_C   = (MAX_ABCD > FLOAT_C) ? MAX_ABCD : FLOAT_C;
    localparam int unsigned CNT_W   = $clog2(MAX_C + 1);

    // Elaboration guard on the pulse width window and on empty phases (R5).
    if (PULSE_NS < 45000 || PULSE_NS > 105000) begin : g_bad_pulse
        $error("PULSE_NS must lie within 45000..105000");
    end
    if (SETUP_C == 0 || HOLD_C == 0 || READ_C == 0 || FLOAT_C == 0) begin : g_bad_phase
        $error("every timed phase needs at least one cycle");
    end

    seq_state_t        state_q;
    logic              tmr_load;
    logic              tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    eprom_pgm_fsm #(
        .ADDR_W (ADDR_W),  .DATA_W (DATA_W), .CNT_W (CNT_W),
        .SETUP_C(SETUP_C), .PULSE_C(PULSE_C), .HOLD_C(HOLD_C),
        .READ_C (READ_C),  .FLOAT_C(FLOAT_C)
    ) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_addr   (cmd_addr),
        .cmd_data   (cmd_data),
        .tmr_expired(tmr_expired),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .state_q    (state_q),
        .addr_q     (addr_q),
        .data_q     (data_q)
    );

    eprom_pgm_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .expired (tmr_expired)
    );

    eprom_pgm_verify #(.DATA_W(DATA_W)) i_verify (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (state_q == ST_READ && tmr_expired),
        .rd_data (mem_dq_in),
        .exp_data(data_q),
        .match_q (pass)
    );

    // Decode the pin levels and status from the current phase.
    always_comb begin
        busy         = (state_q != ST_IDLE);
        done         = (state_q == ST_DONE);
        vcc_hi_en    = (state_q != ST_IDLE) && (state_q != ST_DONE);
        vpp_en       = state_q inside {ST_SETUP, ST_PULSE, ST_HOLD, ST_RELEASE, ST_READ, ST_FLOAT};
        mem_dq_oe    = state_q inside {ST_SETUP, ST_PULSE, ST_HOLD};
        mem_ce_pgm_n = (state_q != ST_PULSE);
        mem_oe_n     = (state_q != ST_READ);
        mem_addr     = addr_q;
        mem_dq_out   = data_q;
    end

    AST_PGM_NEEDS_SUPPLIES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_pgm_n |-> (vpp_en && vcc_hi_en)); // R3
    AST_VPP_INSIDE_VCC: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_en |-> vcc_hi_en); // R2
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> !mem_dq_oe); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_PULSE_SETUP_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ce_pgm_n) |-> (mem_dq_oe && mem_oe_n)); // R4
    AST_BUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(mem_addr) && $stable(mem_dq_out))); // R11

endmodule

// File: tb/test_eprom_pgm_seq.sv
`timescale 1ns/1ps
module test_eprom_pgm_seq;

    localparam int CLK_NS  = 5;
    localparam int SETUP_C = (1000  + CLK_NS - 1) / CLK_NS;
    localparam int PULSE_C = (50000 + CLK_NS - 1) / CLK_NS;
    localparam int HOLD_C  = (1000  + CLK_NS - 1) / CLK_NS;
    localparam int READ_C  = (100   + CLK_NS - 1) / CLK_NS;
    localparam int FLOAT_C = (60    + CLK_NS - 1) / CLK_NS;

    // {address, data, read-back flip mask}
    localparam int NVEC = 4;
    localparam logic [34:0] VEC [NVEC] = '{
        {19'h00000, 8'hA5, 8'h00},
        {19'h7FFFF, 8'h5A, 8'h00},
        {19'h2AAAA, 8'hFF, 8'h01},
        {19'h55555, 8'h00, 8'h80}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [18:0] cmd_addr = '0;
    logic [7:0]  cmd_data = '0;
    logic        busy, done, pass, mem_dq_oe, mem_oe_n, mem_ce_pgm_n, vcc_hi_en, vpp_en;
    logic [18:0] mem_addr;
    logic [7:0]  mem_dq_out, mem_dq_in;
    logic [7:0]  prog_byte = '0;
    logic [7:0]  inject = '0;
    int          cyc = 0;
    int          n_checks = 0;
    int          n_fail = 0;

    always #(CLK_NS / 2.0) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // EPROM model: returns the programmed byte, optionally corrupted.
    assign mem_dq_in = mem_oe_n ? 8'h00 : (prog_byte ^ inject);

    eprom_pgm_seq i_eprom_pgm_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .busy(busy), .done(done), .pass(pass),
        .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in), .mem_oe_n(mem_oe_n), .mem_ce_pgm_n(mem_ce_pgm_n),
        .vcc_hi_en(vcc_hi_en), .vpp_en(vpp_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [18:0] a, input logic [7:0] d,
                          input logic [7:0] inj, input bit poke);
        int t_vcc_on = -1, t_vpp_on = -1, t_dq_on = -1, t_ce_fall = -1, t_ce_rise = -1;
        int t_dq_off = -1, t_oe_fall = -1, t_oe_rise = -1, t_vpp_off = -1, t_vcc_off = -1;
        int t_done = -1, n_done = 0, bad_bus = 0, bad_ce = 0, overlap = 0, n = 0;
        logic pv_vcc, pv_vpp, pv_ce, pv_dq, pv_oe, pass_seen;
        pass_seen = 1'b0;
        @(negedge clk);
        cmd_addr = a; cmd_data = d; inject = inj; cmd_valid = 1'b1;
        pv_vcc = vcc_hi_en; pv_vpp = vpp_en; pv_ce = mem_ce_pgm_n; pv_dq = mem_dq_oe; pv_oe = mem_oe_n;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (n < 20000 && n_done == 0) begin
            if (vcc_hi_en && !pv_vcc) t_vcc_on = cyc;
            if (!vcc_hi_en && pv_vcc) t_vcc_off = cyc;
            if (vpp_en && !pv_vpp) t_vpp_on = cyc;
            if (!vpp_en && pv_vpp) t_vpp_off = cyc;
            if (mem_dq_oe && !pv_dq) t_dq_on = cyc;
            if (!mem_dq_oe && pv_dq) t_dq_off = cyc;
            if (!mem_ce_pgm_n && pv_ce) begin
                t_ce_fall = cyc;
                prog_byte = mem_dq_out;
                check(mem_addr == a && mem_dq_out == d && mem_oe_n, "R4 bus at pulse start",
                      int'(mem_addr), int'(a));
            end
            if (mem_ce_pgm_n && !pv_ce) t_ce_rise = cyc;
            if (!mem_oe_n && pv_oe) t_oe_fall = cyc;
            if (mem_oe_n && !pv_oe) t_oe_rise = cyc;
            if (busy && (mem_addr !== a || mem_dq_out !== d)) bad_bus++;
            if (!mem_ce_pgm_n && !(vpp_en && vcc_hi_en)) bad_ce++;
            if (!mem_oe_n && mem_dq_oe) overlap++;
            if (done) begin n_done++; t_done = cyc; pass_seen = pass; end
            pv_vcc = vcc_hi_en; pv_vpp = vpp_en; pv_ce = mem_ce_pgm_n; pv_dq = mem_dq_oe; pv_oe = mem_oe_n;
            if (poke && n == 50) begin cmd_valid = 1'b1; cmd_addr = ~a; cmd_data = ~d; end
            if (poke && n == 51) cmd_valid = 1'b0;
            n++;
            @(negedge clk);
        end
        check(n_done == 1, "R10 one done per command", n_done, 1);
        check(t_vpp_on - t_vcc_on == 1, "R2 core before programming supply", t_vpp_on - t_vcc_on, 1);
        check(t_vcc_off - t_vpp_off == 1, "R2 core off after programming supply", t_vcc_off - t_vpp_off, 1);
        check(bad_ce == 0, "R3 strobe low only with supplies on", bad_ce, 0);
        check(t_dq_on == t_vpp_on, "R4 data driven with supply enable", t_dq_on, t_vpp_on);
        check(t_ce_fall - t_vpp_on == SETUP_C, "R4 setup cycles", t_ce_fall - t_vpp_on, SETUP_C);
        check(t_ce_rise - t_ce_fall == PULSE_C, "R5 pulse cycles", t_ce_rise - t_ce_fall, PULSE_C);
        check(t_dq_off - t_ce_rise == HOLD_C, "R6 hold cycles", t_dq_off - t_ce_rise, HOLD_C);
        check(bad_bus == 0, "R6 R11 address/data stable while busy", bad_bus, 0);
        check(t_oe_fall - t_dq_off == 1, "R7 release before read", t_oe_fall - t_dq_off, 1);
        check(overlap == 0, "R7 no drive during read", overlap, 0);
        check(t_oe_rise - t_oe_fall == READ_C, "R8 read cycles", t_oe_rise - t_oe_fall, READ_C);
        check(t_vpp_off - t_oe_rise == FLOAT_C, "R9 float cycles", t_vpp_off - t_oe_rise, FLOAT_C);
        check(t_done == t_vcc_off, "R10 done with core supply off", t_done, t_vcc_off);
        check(pass_seen == (inj == 8'h00), "R10 pass flag", int'(pass_seen), int'(inj == 8'h00));
        check(!busy && !done, "R10 idle after done", int'(busy), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset levels
        check(mem_ce_pgm_n && mem_oe_n && !vcc_hi_en && !vpp_en && !mem_dq_oe && !busy && !done,
              "R1 reset state", int'({mem_ce_pgm_n, mem_oe_n, vcc_hi_en, vpp_en, mem_dq_oe, busy, done}),
              7'b1100000);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !vcc_hi_en, "R1 idle after reset release", int'(busy), 0);

        for (int i = 0; i < NVEC; i++)
            run_op(VEC[i][34:16], VEC[i][15:8], VEC[i][7:0], 1'b0);

        // R11: a second command mid-run leaves the running one untouched.
        run_op(19'h12345, 8'h3C, 8'h00, 1'b1);
        begin
            int starts = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (vcc_hi_en || busy) starts++;
            end
            check(starts == 0, "R11 strobe while busy not replayed", starts, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule